// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Controller

This block sits between a byte-wide host request stream and a bank of eight 16K x 1 dynamic RAM devices. All eight devices share one 7-bit address bus, one row strobe, one column strobe and one write strobe. Each device supplies one bit of the byte. A host transfer carries a 14-bit byte address, a write flag and a write byte. The controller splits the address into a row half and a column half. It sends them one after the other on the shared bus, under row and column strobes that it drives low in turn. On a read it captures the byte from the devices' data outputs.

The controller also keeps the memory alive without the host. After reset it runs a fixed number of row-only warm-up cycles before it accepts any request. From then on a timer requests one row-only refresh cycle per interval, and the controller walks all rows in turn. Every analogue timing limit is a nanosecond parameter. These are turned into clock counts from the clock-period parameter: minimums are rounded up and maximums rounded down.

The request side is valid/ready. `req_ready` is high only while the sequencer is idle, warm-up is finished and no refresh is waiting. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The host must keep the request fields stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a one-clock pulse and the host must take it when it comes.

Top module: `dramc_ctrl`

## Requirements
- R1: The host address is split as row = `req_addr[13:7]` and column = `req_addr[6:0]`. The row is on `dram_addr` when the row strobe falls, and the column is on it when the column strobe falls. Byte bit i goes to `dram_din[i]` and comes back on `dram_dout[i]`.
- R2: The row is on `dram_addr` at least one clock before `dram_ras_n` falls and stays there for at least 25 ns after the fall. The column does not change while `dram_cas_n` is low.
- R3: `dram_cas_n` is low only while `dram_ras_n` is low. On a host cycle it falls 25 ns to 65 ns after `dram_ras_n` falls, and it stays low for at least 135 ns.
- R4: Each row-strobe low time lies between 200 ns and 1000 ns. Each high time (precharge) between two low times is at least 120 ns. Successive row-strobe falls are at least 375 ns apart.
- R5: Writes use early write: `dram_we_n` is already low a clock before `dram_cas_n` falls, and `dram_din` holds the byte when `dram_cas_n` falls. On reads and on row-only cycles `dram_we_n` stays high.
- R6: On a read the byte is sampled from `dram_dout` in the last clock that `dram_cas_n` is low, and it is shown on `rsp_rdata` with a one-clock `rsp_valid` pulse. A write also ends with a one-clock `rsp_valid` pulse. Data read back equals the data last written to the same address.
- R7: After reset the strobes are high, `req_ready` and `rsp_valid` are low, and exactly 8 row-only cycles run before `req_ready` first rises.
- R8: A refresh cycle drives the row strobe low while the column strobe stays high. Refresh (and warm-up) rows follow a counter that starts at 0, goes up by one per cycle and wraps from 127 to 0.
- R9: A refresh is requested every refresh-window / 128 clocks. A waiting refresh wins over a waiting host request but never cuts a cycle short, so successive refresh cycles are no more than one interval plus one memory cycle apart.
- R10: `req_ready` is low from the clock after a request is accepted until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address, row in upper half |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock pulse marking transfer completion |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_valid` on reads |
| dram_addr | output | 7 | Shared multiplexed row/column address bus |
| dram_ras_n | output | 1 | Shared row strobe, active low |
| dram_cas_n | output | 1 | Shared column strobe, active low |
| dram_we_n | output | 1 | Shared write strobe, active low |
| dram_din | output | 8 | Per-device data-in bits |
| dram_dout | input | 8 | Per-device data-out bits |

## Verification
The main function is tried with writes and reads to the two extreme addresses, to a pair of addresses that share a column but differ in row, and to an address that is written twice. The pair with the shared column tells whether row and column land in the right halves. The double write tells whether the latest data wins. Long streams of back-to-back requests show whether refresh still wins while a request is always waiting. A long idle run shows whether the row counter wraps. A behavioural memory model watches the strobe edges and measures every low time and high time against the nanosecond limits.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_PRE   = 2'd3
  } seq_state_t;

  // Smallest clock count whose duration is at least ns.
  function automatic int ns_to_clk_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
  parameter int INT_C  = 1953,
  parameter int ROW_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int TMR_W = $clog2(INT_C + 1);

  logic [TMR_W-1:0] tmr;
  logic             tick;

  assign tick = (tmr == TMR_W'(INT_C - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tmr     <= tick ? '0 : tmr + 1'b1;
      pending <= tick | (pending & ~take);
      if (take) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/dramc_init.sv
module dramc_init #(
  parameter int DUMMY_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic done
);
  localparam int CW = $clog2(DUMMY_N + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(DUMMY_N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (take && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int ABUS_W     = 7,
  parameter int DATA_W     = 8,
  parameter int ROW_HOLD_C = 4,
  parameter int CAS_AT_C   = 5,
  parameter int RAS_LO_C   = 25,
  parameter int PRE_C      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_ref,
  input  logic              wr,
  input  logic [ABUS_W-1:0] row,
  input  logic [ABUS_W-1:0] col,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dout,
  output logic              idle,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ABUS_W-1:0] addr,
  output logic [DATA_W-1:0] din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CNT_W = $clog2(imax(RAS_LO_C, PRE_C) + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              c_ref, c_wr;
  logic [ABUS_W-1:0] c_col;
  logic [DATA_W-1:0] c_data;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      c_ref     <= 1'b0;
      c_wr      <= 1'b0;
      c_col     <= '0;
      c_data    <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      addr      <= '0;
      din       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SETUP;
          addr   <= row;
          c_ref  <= start_ref;
          c_wr   <= wr & ~start_ref;
          c_col  <= col;
          c_data <= wdata;
        end
        ST_SETUP: begin
          state <= ST_ACT;
          cnt   <= '0;
          ras_n <= 1'b0;
          we_n  <= ~c_wr;
          din   <= c_data;
        end
        ST_ACT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(ROW_HOLD_C - 1) && !c_ref) addr <= c_col;
          if (cnt == CNT_W'(CAS_AT_C - 1) && !c_ref) cas_n <= 1'b0;
          if (cnt == CNT_W'(RAS_LO_C - 1)) begin
            state <= ST_PRE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            if (!c_ref) begin
              rsp_valid <= 1'b1;
              if (!c_wr) rsp_data <= dout;
            end
          end
        end
        ST_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(PRE_C - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
  import dramc_pkg::*;
#(
  parameter int CLK_NS       = 8,
  parameter int ABUS_W       = 7,
  parameter int DATA_W       = 8,
  parameter int DUMMY_N      = 8,
  parameter int T_RAS_MIN_NS = 200,
  parameter int T_RAS_MAX_NS = 1000,
  parameter int T_RP_NS      = 120,
  parameter int T_RC_NS      = 375,
  parameter int T_RCD_MIN_NS = 25,
  parameter int T_RAH_NS     = 25,
  parameter int T_CAS_NS     = 135,
  parameter int REF_WIN_NS   = 2_000_000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [2*ABUS_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ABUS_W-1:0]     dram_addr,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic [DATA_W-1:0]     dram_din,
  input  logic [DATA_W-1:0]     dram_dout
);
  localparam int ROWS       = 1 << ABUS_W;
  localparam int RCD_MIN_C  = ns_to_clk_up(T_RCD_MIN_NS, CLK_NS);
  localparam int ROW_HOLD_C = ns_to_clk_up(T_RAH_NS, CLK_NS);
  localparam int CAS_AT_C   = imax(RCD_MIN_C, ROW_HOLD_C + 1);
  localparam int CAS_LO_C   = ns_to_clk_up(T_CAS_NS, CLK_NS);
  localparam int RAS_LO_C   = imax(ns_to_clk_up(T_RAS_MIN_NS, CLK_NS), CAS_AT_C + CAS_LO_C);
  localparam int HI_MIN_C   = ns_to_clk_up(T_RP_NS, CLK_NS);
  localparam int PRE_C      = imax(1, imax(HI_MIN_C - 2,
                                   ns_to_clk_up(T_RC_NS, CLK_NS) - RAS_LO_C - 2));
  localparam int RAS_MAX_C  = T_RAS_MAX_NS / CLK_NS;
  localparam int REF_INT_C  = REF_WIN_NS / ROWS / CLK_NS;

  logic              seq_idle, init_done, ref_pending;
  logic              grant_ref, grant_host;
  logic [ABUS_W-1:0] ref_row, row_sel;

  assign req_ready  = seq_idle & init_done & ~ref_pending;
  assign grant_ref  = seq_idle & (ref_pending | ~init_done);
  assign grant_host = req_valid & req_ready;
  assign row_sel    = grant_ref ? ref_row : req_addr[2*ABUS_W-1:ABUS_W];

  dramc_refresh #(.INT_C(REF_INT_C), .ROW_W(ABUS_W)) refresh_i (
    .clk(clk), .rst_n(rst_n), .take(grant_ref),
    .pending(ref_pending), .row(ref_row)
  );

  dramc_init #(.DUMMY_N(DUMMY_N)) init_i (
    .clk(clk), .rst_n(rst_n), .take(grant_ref), .done(init_done)
  );

  dramc_seq #(
    .ABUS_W(ABUS_W), .DATA_W(DATA_W), .ROW_HOLD_C(ROW_HOLD_C),
    .CAS_AT_C(CAS_AT_C), .RAS_LO_C(RAS_LO_C), .PRE_C(PRE_C)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(grant_ref | grant_host), .start_ref(grant_ref),
    .wr(req_write), .row(row_sel), .col(req_addr[ABUS_W-1:0]),
    .wdata(req_wdata), .dout(dram_dout), .idle(seq_idle),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .addr(dram_addr), .din(dram_din),
    .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );
endmodule

// File: rtl/dramc_chk.sv
module dramc_chk #(
  parameter int ABUS_W    = 7,
  parameter int RAS_MAX_C = 125,
  parameter int HI_MIN_C  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ABUS_W-1:0] addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              init_done
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'(HI_MIN_C);
    end else if (ras_n) begin
      lo_cnt <= '0;
      if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R4
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= 16'(RAS_MAX_C));
  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 16'(HI_MIN_C));
  // R3
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));
  // R2
  col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(addr));
  // R7
  init_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind dramc_ctrl dramc_chk #(
  .ABUS_W(ABUS_W), .RAS_MAX_C(RAS_MAX_C), .HI_MIN_C(HI_MIN_C)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .addr(dram_addr), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .init_done(init_done)
);

// File: tb/dramc_ctrl_tb_top.sv
module dramc_ctrl_tb_top;
  localparam int CLK_NS  = 8;
  localparam int REF_WIN = 512000;
  localparam int REF_INT = REF_WIN / 128 / CLK_NS;
  localparam int CYC_MAX = 52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n;
  logic [7:0] rsp_rdata, din, dout;
  logic [6:0] addr;

  int total = 0, bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  dramc_ctrl #(.CLK_NS(CLK_NS), .REF_WIN_NS(REF_WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_din(din), .dram_dout(dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural memory: eight 1-bit devices seen as one byte array.
  logic [7:0] mem [int];
  logic [6:0] m_row, m_col;
  always @(negedge ras_n) m_row = addr;
  always @(negedge cas_n) begin
    m_col = addr;
    if (!we_n) mem[{18'd0, m_row, m_col}] = din;
  end
  always @* begin
    if (!cas_n && we_n && mem.exists({18'd0, m_row, m_col}))
      dout = mem[{18'd0, m_row, m_col}];
    else
      dout = 8'h00;
  end

  // Strobe timing monitor
  logic        cur_wr = 0;
  logic [13:0] cur_addr = '0;
  logic [7:0]  cur_data = '0;
  logic        p_ras = 1, p_cas = 1, p_we = 1;
  logic [6:0]  p_addr = '0, ras_row = '0, ref_exp = '0, last_ref = '0;
  int lo_len = 0, hi_len = 0, cas_lo = 0, hold_len = 0, prev_lo = 0;
  int since_ref = 0, ref_idx = 0, dummies = 0;
  bit saw_cas = 0, saw_we = 0, col_moved = 0, any_fall = 0, wrap_seen = 0, ready_seen = 0;

  always @(negedge clk) if (rst_n && !done_flag) begin
    since_ref++;
    if (!ras_n && p_ras) begin
      if (any_fall) begin
        chk(hi_len * CLK_NS >= 120, "R4 precharge", hi_len, 15);
        chk((hi_len + prev_lo) * CLK_NS >= 375, "R4 cycle", hi_len + prev_lo, 47);
      end
      chk(p_addr == addr, "R2 row setup", p_addr, addr);
      any_fall = 1; ras_row = addr; lo_len = 1; hold_len = 1;
      saw_cas = 0; col_moved = 0; saw_we = !we_n;
    end else if (!ras_n) begin
      lo_len++;
      if (!we_n) saw_we = 1;
      if (!col_moved && addr != ras_row) begin
        col_moved = 1;
        chk(hold_len * CLK_NS >= 25, "R2 row hold", hold_len, 4);
      end else if (!col_moved) hold_len++;
    end
    if (!cas_n && p_cas) begin
      chk((lo_len - 1) * CLK_NS >= 25 && (lo_len - 1) * CLK_NS <= 65, "R3 ras-to-cas", lo_len - 1, 5);
      chk(ras_row == cur_addr[13:7], "R1 row", ras_row, cur_addr[13:7]);
      chk(addr == cur_addr[6:0], "R1 column", addr, cur_addr[6:0]);
      chk(we_n == !cur_wr, "R5 write strobe", we_n, !cur_wr);
      if (cur_wr) begin
        chk(!p_we, "R5 early write", p_we, 0);
        chk(din == cur_data, "R5 data-in", din, cur_data);
      end
      saw_cas = 1; cas_lo = 1;
    end else if (!cas_n) cas_lo++;
    if (ras_n && !p_ras) begin
      chk(lo_len * CLK_NS >= 200 && lo_len * CLK_NS <= 1000, "R4 ras low", lo_len, 25);
      if (saw_cas) chk(cas_lo * CLK_NS >= 135, "R3 cas low", cas_lo, 17);
      else begin
        chk(!saw_we, "R5 refresh we", saw_we, 0);
        chk(ras_row == ref_exp, "R8 refresh row", ras_row, ref_exp);
        if (ref_idx > 0 && last_ref == 7'd127 && ras_row == 7'd0) wrap_seen = 1;
        if (ref_idx >= 10)
          chk(since_ref >= REF_INT - CYC_MAX && since_ref <= REF_INT + CYC_MAX,
              "R9 refresh gap", since_ref, REF_INT);
        last_ref = ras_row; ref_exp = ras_row + 1'b1;
        ref_idx++; since_ref = 0;
        if (!ready_seen) dummies++;
      end
      prev_lo = lo_len; hi_len = 1;
    end else if (ras_n) hi_len++;
    if (req_ready && !ready_seen) begin
      ready_seen = 1;
      chk(dummies == 8, "R7 dummy count", dummies, 8);
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
  end

  task automatic do_req(input bit wr, input logic [13:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    int n;
    @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_data = d;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy", req_ready, 0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk(rsp_valid, "R6 response", rsp_valid, 1);
    q = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R6 pulse", rsp_valid, 0);
  endtask

  // {write, addr[13:0], wdata, expected read}
  localparam logic [30:0] VEC [0:10] = '{
    {1'b1, 14'h0000, 8'hA5, 8'h00},
    {1'b1, 14'h3FFF, 8'h5A, 8'h00},
    {1'b1, 14'h2A55, 8'h3C, 8'h00},
    {1'b1, 14'h1580, 8'hC3, 8'h00},
    {1'b1, 14'h0080, 8'h11, 8'h00},
    {1'b0, 14'h0000, 8'h00, 8'hA5},
    {1'b0, 14'h3FFF, 8'h00, 8'h5A},
    {1'b1, 14'h2A55, 8'h99, 8'h00},
    {1'b0, 14'h2A55, 8'h00, 8'h99},
    {1'b0, 14'h1580, 8'h00, 8'hC3},
    {1'b0, 14'h0080, 8'h00, 8'h11}
  };

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] q;
    int n, refs0;
    repeat (5) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R7 reset strobes", {ras_n, cas_n, we_n}, 3'b111);
    chk(!req_ready, "R7 reset ready", req_ready, 0);
    chk(!rsp_valid, "R6 reset response", rsp_valid, 0);
    rst_n = 1;
    n = 0;
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    chk(req_ready, "R7 ready after warm-up", req_ready, 1);
    for (int i = 0; i < 11; i++) begin
      do_req(VEC[i][30], VEC[i][29:16], VEC[i][15:8], q);
      if (!VEC[i][30]) chk(q == VEC[i][7:0], "R6 read data", q, VEC[i][7:0]);
    end
    refs0 = ref_idx;
    for (int i = 0; i < 40; i++) begin
      do_req(1'b0, 14'h3FFF, 8'h00, q);
      chk(q == 8'h5A, "R6 burst read", q, 8'h5A);
    end
    chk(ref_idx - refs0 >= 2, "R9 refresh under load", ref_idx - refs0, 2);
    n = 0;
    while (ref_idx < 132 && n < 90000) begin @(negedge clk); n++; end
    chk(wrap_seen, "R8 row wrap", wrap_seen, 1);
    do_req(1'b0, 14'h2A55, 8'h00, q);
    chk(q == 8'h99, "R6 read after refresh", q, 8'h99);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule